// File: doc/BRIEF.md
# ADC Auto-Trigger Start Selector

This block decides when an analog-to-digital converter begins an automatic conversion. A small control register holds a 3-bit source code. The code picks one of six interrupt-flag inputs or the converter's own conversion-complete flag. The block watches the chosen signal. When that signal goes from low to high, it issues a one-clock start pulse. The pulse is gated by an auto-trigger enable and a converter enable. Nothing is held back for later: a start that arrives while the gates are closed is lost.

The rising edge is detected after the selection multiplexer, not on each flag separately. A change of source code is therefore an event in its own right. Moving from a source whose flag is low to one whose flag is high counts as a rising edge and starts a conversion. Moving into free-running mode is the one exception. In that mode the trigger is the conversion-complete flag, so each completion starts the next conversion. Entering the mode never starts a conversion by itself, even when the completion flag is already high.

Top module: `adcAutoTrigSel`

## Requirements
- R1: After reset, the source code is 000 and regRdData reads 0x00. A write places regWrData[2:0] in the source code. regRdData returns the source code in bits 2:0, and bits 7:3 always read 0.
- R2: Source codes 001 to 110 select flagIn[code-1]. Bit 0 is the analog comparator, bit 1 external interrupt 0, bit 2 timer compare match A, bit 3 timer overflow, bit 4 timer compare match B and bit 5 pin change.
- R3: With both enables high, the selected signal may be sampled 1 on a clock edge after being sampled 0 on the edge before it. startPulse is then high for exactly the one cycle that follows that edge.
- R4: Flags that are not selected have no effect on startPulse.
- R5: Suppose the code is rewritten from a source whose flag is low to a source whose flag is high. With both enables high, startPulse goes high one cycle after the write takes effect.
- R6: Source code 000 (free running) uses convDone as the trigger signal, and each rising edge of convDone produces a start pulse.
- R7: Rewriting the code from a nonzero value to 000 produces no start pulse, even when convDone is already high.
- R8: Source code 111 is a constant-low source and never produces a start pulse.
- R9: While autoTrigEn is 0, startPulse stays 0.
- R10: While convEn is 0, startPulse stays 0. An edge that occurs in that time is not delivered later when convEn returns to 1.
- R11: A selected flag held high produces only one start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the control register |
| regWrData | input | 8 | Write data; bits 2:0 are the source code |
| regRdData | output | 8 | Register read value; bits 7:3 are zero |
| autoTrigEn | input | 1 | Auto-trigger enable |
| convEn | input | 1 | Converter enable |
| flagIn | input | 6 | Interrupt flags of the six trigger sources |
| convDone | input | 1 | Conversion-complete flag (free-running trigger) |
| startPulse | output | 1 | One-cycle conversion start request |

## Verification
The bench goes after source switching. A design that finds edges on each flag separately would miss the trigger caused by switching to a source that is already high. A design that does not reset its history on entry to free-running mode would start a conversion when code 000 is written while convDone is high. The bench holds a flag high while convEn is low and then raises convEn, to catch a design that queues the edge or re-arms on the enable. Code 111 and a held-high flag catch a decoder that falls through to a live input, and an edge detector that fires at a level instead of an edge.

// File: rtl/adcTrigPkg.sv
package adcTrigPkg;
  localparam int SEL_W = 3;
  localparam int REG_W = 8;

  typedef enum logic [SEL_W-1:0] {
    SRC_FREE  = 3'd0,
    SRC_ACOMP = 3'd1,
    SRC_EXT0  = 3'd2,
    SRC_CMPA  = 3'd3,
    SRC_OVF   = 3'd4,
    SRC_CMPB  = 3'd5,
    SRC_PCHG  = 3'd6,
    SRC_NONE  = 3'd7
  } trigSrcE;

  // Strobes passed from control to datapath
  typedef struct packed {
    trigSrcE sel;        // current source code
    logic    forceFree;  // write is moving the code into free running
  } ctrlStrobeT;
endpackage

// File: rtl/trigCtrl.sv
module trigCtrl
  import adcTrigPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output ctrlStrobeT       strb
);
  localparam int PAD_W = REG_W - SEL_W;

  trigSrcE selQ;

  always_ff @(posedge clk) begin
    if (!rstN)
      selQ <= SRC_FREE;
    else if (regWrEn)
      selQ <= trigSrcE'(regWrData[SEL_W-1:0]);
  end

  always_comb begin
    strb.sel       = selQ;
    strb.forceFree = regWrEn && (regWrData[SEL_W-1:0] == SEL_W'(0)) && (selQ != SRC_FREE);
    regRdData      = {{PAD_W{1'b0}}, selQ};
  end

  // R1: a write lands in the source code on the next edge
  a_r1_write_loads: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(regWrEn)) |-> (selQ == trigSrcE'($past(regWrData[SEL_W-1:0]))));
endmodule

// File: rtl/trigDatapath.sv
module trigDatapath
  import adcTrigPkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strb,
  input  logic [NUM_SRC-1:0] flagIn,
  input  logic               convDone,
  input  logic               autoTrigEn,
  input  logic               convEn,
  output logic               startPulse
);
  logic trigNow;
  logic trigPrev;
  logic edgeSeen;
  logic gateOpen;

  // Trigger multiplexer: code 0 is the completion flag, codes 1..NUM_SRC the flags
  always_comb begin
    trigNow = 1'b0;
    if (strb.sel == SRC_FREE)
      trigNow = convDone;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strb.sel == trigSrcE'(i + 1))
        trigNow = flagIn[i];
    end
  end

  // History of the muxed signal; loaded with convDone when entering free running
  always_ff @(posedge clk) begin
    if (!rstN)
      trigPrev <= 1'b0;
    else if (strb.forceFree)
      trigPrev <= convDone;
    else
      trigPrev <= trigNow;
  end

  assign edgeSeen = trigNow & ~trigPrev;
  assign gateOpen = autoTrigEn & convEn;

  always_ff @(posedge clk) begin
    if (!rstN)
      startPulse <= 1'b0;
    else
      startPulse <= edgeSeen & gateOpen;
  end

  // R9 R10: a pulse only follows a cycle with both enables high
  a_r9_r10_gated: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(autoTrigEn && convEn));

  // R8: the reserved code never yields a start
  a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(strb.sel != SRC_NONE));

  // R7: entering free running with convDone high gives no start on the following decision
  a_r7_free_entry: assert property (@(posedge clk) disable iff (!rstN)
    (strb.forceFree && convDone) |=> ##1 !startPulse);

  // R11: a pulse is never followed by another while the selected signal stays high
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && trigNow && $stable(strb.sel) && !strb.forceFree) |=> !startPulse);
endmodule

// File: rtl/adcAutoTrigSel.sv
module adcAutoTrigSel
  import adcTrigPkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic               autoTrigEn,
  input  logic               convEn,
  input  logic [NUM_SRC-1:0] flagIn,
  input  logic               convDone,
  output logic               startPulse
);
  ctrlStrobeT strb;

  trigCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strb      (strb)
  );

  trigDatapath #(.NUM_SRC(NUM_SRC)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .flagIn     (flagIn),
    .convDone   (convDone),
    .autoTrigEn (autoTrigEn),
    .convEn     (convEn),
    .startPulse (startPulse)
  );
endmodule

// File: tb/adcAutoTrigSel_tb_top.sv
module adcAutoTrigSel_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       autoTrigEn;
  logic       convEn;
  logic [5:0] flagIn;
  logic       convDone;
  logic       startPulse;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  adcAutoTrigSel dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .autoTrigEn(autoTrigEn), .convEn(convEn),
    .flagIn(flagIn), .convDone(convDone), .startPulse(startPulse)
  );

  // {code[2:0], flags[5:0], convDone, expected startPulse}
  localparam int NVEC = 12;
  localparam logic [10:0] VECS [NVEC] = '{
    {3'd1, 6'b000001, 1'b0, 1'b1},
    {3'd1, 6'b111110, 1'b1, 1'b0},
    {3'd2, 6'b000010, 1'b0, 1'b1},
    {3'd3, 6'b000100, 1'b0, 1'b1},
    {3'd4, 6'b001000, 1'b0, 1'b1},
    {3'd5, 6'b010000, 1'b0, 1'b1},
    {3'd6, 6'b100000, 1'b0, 1'b1},
    {3'd6, 6'b011111, 1'b1, 1'b0},
    {3'd0, 6'b000000, 1'b1, 1'b1},
    {3'd0, 6'b111111, 1'b0, 1'b0},
    {3'd7, 6'b111111, 1'b1, 1'b0},
    {3'd3, 6'b111011, 1'b1, 1'b0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeCode(input logic [7:0] v);
    regWrEn   = 1'b1;
    regWrData = v;
    step();
    regWrEn   = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regWrData = 8'h00;
    autoTrigEn = 1'b0; convEn = 1'b0; flagIn = 6'b0; convDone = 1'b0;
    #1;
    step(); step(); step();
    check("R1 reset read", regRdData, 8'h00);
    check("R1 reset pulse", {7'b0, startPulse}, 8'h00);
    rstN = 1'b1;
    autoTrigEn = 1'b1; convEn = 1'b1;
    step();

    // Table: R2 R3 R4 R6 R8
    for (int v = 0; v < NVEC; v++) begin
      flagIn = 6'b0; convDone = 1'b0;
      writeCode({5'b0, VECS[v][10:8]});
      step();
      flagIn   = VECS[v][7:2];
      convDone = VECS[v][1];
      step();
      check($sformatf("R2 R3 R4 R6 R8 vector %0d", v), {7'b0, startPulse}, {7'b0, VECS[v][0]});
    end
    flagIn = 6'b0; convDone = 1'b0;
    step(); step();

    // R1: reserved bits read zero
    writeCode(8'hFF);
    check("R1 read FF", regRdData, 8'h07);
    writeCode(8'hA5);
    check("R1 read A5", regRdData, 8'h05);

    // R11: held flag gives one pulse
    writeCode(8'h01);
    step();
    flagIn = 6'b000001;
    step();
    check("R11 first", {7'b0, startPulse}, 8'h01);
    step();
    check("R11 held", {7'b0, startPulse}, 8'h00);
    step();
    check("R11 held later", {7'b0, startPulse}, 8'h00);

    // R5: switch from low source to high source
    flagIn = 6'b000010;
    step();
    writeCode(8'h02);
    check("R5 write edge", {7'b0, startPulse}, 8'h00);
    step();
    check("R5 switch trigger", {7'b0, startPulse}, 8'h01);
    step();

    // R7: switch into free running with convDone high
    flagIn = 6'b0;
    writeCode(8'h01);
    convDone = 1'b1;
    step(); step();
    writeCode(8'h00);
    check("R7 write edge", {7'b0, startPulse}, 8'h00);
    step();
    check("R7 after entry", {7'b0, startPulse}, 8'h00);
    step();
    check("R7 later", {7'b0, startPulse}, 8'h00);
    // R6: next completion starts again
    convDone = 1'b0;
    step();
    convDone = 1'b1;
    step();
    check("R6 completion restart", {7'b0, startPulse}, 8'h01);
    convDone = 1'b0;

    // R9: auto-trigger disabled
    writeCode(8'h01);
    autoTrigEn = 1'b0;
    step();
    flagIn = 6'b000001;
    step();
    check("R9 disabled", {7'b0, startPulse}, 8'h00);
    step();
    check("R9 disabled later", {7'b0, startPulse}, 8'h00);
    autoTrigEn = 1'b1;
    flagIn = 6'b0;
    step();

    // R10: converter disabled, no queued start
    convEn = 1'b0;
    step();
    flagIn = 6'b000001;
    step();
    check("R10 disabled", {7'b0, startPulse}, 8'h00);
    convEn = 1'b1;
    step();
    check("R10 not queued", {7'b0, startPulse}, 8'h00);
    step();
    check("R10 not queued later", {7'b0, startPulse}, 8'h00);

    // R8: reserved code with everything high
    flagIn = 6'b0;
    writeCode(8'h07);
    step();
    flagIn = 6'b111111; convDone = 1'b1;
    step();
    check("R8 reserved code", {7'b0, startPulse}, 8'h00);
    step();
    check("R8 reserved code later", {7'b0, startPulse}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule